// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block produces the serial clock waveform for an I2C master from the chip's functional clock. The functional clock is first divided by a programmable prescaler, giving a one-cycle enable pulse that acts as the internal sampling clock. Each SCL phase is then timed in units of those pulses. The low phase runs for its programmed count plus a fixed offset of 7 ticks. The high phase runs for its programmed count plus a fixed offset of 5 ticks. One full SCL period therefore spans (psc+1) x (low + 7 + high + 5) functional-clock cycles. With a 48 MHz clock and psc = 1, the count pairs (111,117), (23,25) and (5,7) give 100 kHz, 400 kHz and 1 MHz.

Each timing input is a 16-bit word. The low byte holds the standard/fast count and the high byte holds the high-speed count; a mode input picks which byte pair is used. Besides the SCL level, the block emits one-cycle strobes to the bit engine:

- a strobe in the middle of the low phase, where data may change;
- a strobe in the middle of the high phase, where data is sampled;
- a strobe in the last cycle of each phase, so that START, STOP and data timing can be aligned to the phase boundaries.

The timing inputs are expected to stay constant while the generator is enabled.

Top module: `scl_rate_gen`

## Requirements
- R1: While enabled, `tick` is high for one cycle out of every psc+1 functional-clock cycles. The first tick comes psc cycles after enable is first seen high, and with psc = 0 `tick` is high every cycle.
- R2: In standard/fast mode (`hs_mode` = 0), the SCL low phase lasts (low_word[7:0] + 7) ticks, which is (psc+1) x (low_word[7:0] + 7) cycles.
- R3: In standard/fast mode, the SCL high phase lasts (high_word[7:0] + 5) ticks, which is (psc+1) x (high_word[7:0] + 5) cycles.
- R4: With `hs_mode` = 1, low_word[15:8] and high_word[15:8] replace the low bytes in R2 and R3; the other byte has no effect.
- R5: After enable, the low phase always comes first. `scl` goes low in the same cycle that `enable` is first high, and phases alternate low, high, low and so on after that.
- R6: While `enable` is low, `scl` is 1, and `tick` and all four strobes are 0. Changing the timing inputs has no visible effect. Re-enabling starts a full low phase from zero, even if the generator was stopped part-way through a phase.
- R7: `low_mid` and `high_mid` each pulse once per phase of their level, on the tick at which the phase tick count (starting from 0) equals floor(phase length / 2). In cycles, that is (psc+1) x floor(len/2) + psc cycles after the phase starts.
- R8: `low_end` and `high_end` each pulse once per phase, in the last cycle of a low phase and of a high phase respectively; `scl` changes level in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator; low holds SCL released |
| hs_mode | input | 1 | 1 selects the high-speed count bytes |
| psc | input | 8 | Prescale value; divides clk by psc+1 |
| low_word | input | 16 | Low-phase counts: [7:0] standard/fast, [15:8] high-speed |
| high_word | input | 16 | High-phase counts: [7:0] standard/fast, [15:8] high-speed |
| tick | output | 1 | Internal sampling-clock enable |
| scl | output | 1 | SCL level (1 = released) |
| low_mid | output | 1 | Strobe at the midpoint of the low phase |
| high_mid | output | 1 | Strobe at the midpoint of the high phase |
| low_end | output | 1 | Strobe in the last cycle of a low phase |
| high_end | output | 1 | Strobe in the last cycle of a high phase |

## Verification
The bench measures each phase in cycles across several prescale values, including psc = 0, and across the extreme counts of 0 and 255. A design that dropped or misplaced a fixed offset, or counted raw clocks instead of ticks, would show phase lengths wrong by a constant or by a factor. The same timing words are run with the mode input both clear and set, so a wrong byte or mixed bytes would show up as a swapped phase length. Stopping the generator part-way through a phase and then restarting it catches a counter that is not cleared, which would cut the first low phase short. The recorded positions of the midpoint and end strobes catch off-by-one decoding of the phase count.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Fixed hardware extension added to each programmed phase count
    localparam int LOW_OFFSET  = 7;
    localparam int HIGH_OFFSET = 5;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_t;

    typedef struct packed {
        logic low_mid;
        logic high_mid;
        logic low_end;
        logic high_end;
    } scl_events_t;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [PSC_W-1:0] div,
    output logic             tick_o
);
    logic [PSC_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt == div)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick_o = en && (cnt == div);
endmodule

// File: rtl/scl_phase_select.sv
module scl_phase_select
    import scl_gen_pkg::*;
#(
    parameter int FIELD_W = 8,
    parameter int LEN_W   = FIELD_W + 1
) (
    input  logic                 hs_mode,
    input  logic [2*FIELD_W-1:0] low_word,
    input  logic [2*FIELD_W-1:0] high_word,
    output logic [LEN_W-1:0]     low_len,
    output logic [LEN_W-1:0]     high_len
);
    logic [FIELD_W-1:0] low_cnt, high_cnt;

    always_comb begin
        if (hs_mode) begin
            low_cnt  = low_word[2*FIELD_W-1:FIELD_W];
            high_cnt = high_word[2*FIELD_W-1:FIELD_W];
        end else begin
            low_cnt  = low_word[FIELD_W-1:0];
            high_cnt = high_word[FIELD_W-1:0];
        end
        low_len  = LEN_W'(low_cnt)  + LEN_W'(LOW_OFFSET);
        high_len = LEN_W'(high_cnt) + LEN_W'(HIGH_OFFSET);
    end
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter
    import scl_gen_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output scl_phase_t       phase_o,
    output scl_events_t      events_o
);
    scl_phase_t       phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic             at_last;
    logic             at_mid;

    always_comb begin
        cur_len = (phase == PH_LOW) ? low_len : high_len;
        at_last = (cnt == cur_len - LEN_W'(1));
        at_mid  = (cnt == (cur_len >> 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            phase <= PH_LOW;
            cnt   <= '0;
        end else if (tick) begin
            if (at_last) begin
                cnt   <= '0;
                phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        events_o.low_mid  = tick && (phase == PH_LOW)  && at_mid;
        events_o.high_mid = tick && (phase == PH_HIGH) && at_mid;
        events_o.low_end  = tick && (phase == PH_LOW)  && at_last;
        events_o.high_end = tick && (phase == PH_HIGH) && at_last;
    end

    assign phase_o = phase;
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_gen_pkg::*;
#(
    parameter int PSC_W   = 8,
    parameter int FIELD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 hs_mode,
    input  logic [PSC_W-1:0]     psc,
    input  logic [2*FIELD_W-1:0] low_word,
    input  logic [2*FIELD_W-1:0] high_word,
    output logic                 tick,
    output logic                 scl,
    output logic                 low_mid,
    output logic                 high_mid,
    output logic                 low_end,
    output logic                 high_end
);
    localparam int LEN_W = FIELD_W + 1;

    logic [LEN_W-1:0] low_len, high_len;
    scl_phase_t       phase;
    scl_events_t      ev;

    scl_prescaler #(.PSC_W(PSC_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .en     (enable),
        .div    (psc),
        .tick_o (tick)
    );

    scl_phase_select #(.FIELD_W(FIELD_W), .LEN_W(LEN_W)) u_sel (
        .hs_mode   (hs_mode),
        .low_word  (low_word),
        .high_word (high_word),
        .low_len   (low_len),
        .high_len  (high_len)
    );

    scl_phase_counter #(.LEN_W(LEN_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .tick     (tick),
        .low_len  (low_len),
        .high_len (high_len),
        .phase_o  (phase),
        .events_o (ev)
    );

    assign scl      = !enable || (phase == PH_HIGH);
    assign low_mid  = ev.low_mid;
    assign high_mid = ev.high_mid;
    assign low_end  = ev.low_end;
    assign high_end = ev.high_end;
endmodule

// File: rtl/scl_rate_gen_checker.sv
module scl_rate_gen_checker #(
    parameter int PSC_W   = 8,
    parameter int FIELD_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enable,
    input logic                 hs_mode,
    input logic [PSC_W-1:0]     psc,
    input logic [2*FIELD_W-1:0] low_word,
    input logic [2*FIELD_W-1:0] high_word,
    input logic                 tick,
    input logic                 scl,
    input logic                 low_mid,
    input logic                 high_mid,
    input logic                 low_end,
    input logic                 high_end
);
    assert_idle_released_R6: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (scl && !tick && !low_mid && !high_mid && !low_end && !high_end));

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && psc != '0) |=> (!tick || !$stable(psc)));

    assert_low_first_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(enable) |-> !scl);

    assert_mid_level_R7: assert property (@(posedge clk) disable iff (rst)
        (low_mid |-> (tick && !scl)) and (high_mid |-> (tick && scl)));

    assert_rise_after_low_end_R8: assert property (@(posedge clk) disable iff (rst)
        low_end |=> scl);

    assert_fall_after_high_end_R8: assert property (@(posedge clk) disable iff (rst)
        high_end |=> (!scl || !enable));

    assert_edge_only_at_end_R2: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !$stable(scl)) |-> $past(low_end || high_end));

    // hs_mode, low_word and high_word are not observed here beyond the port list
    logic unused_ok;
    assign unused_ok = ^{hs_mode, low_word, high_word};
endmodule

bind scl_rate_gen scl_rate_gen_checker #(.PSC_W(PSC_W), .FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/scl_rate_gen_bench.sv
`timescale 1ns/1ps
module scl_rate_gen_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic        hs_mode;
    logic [7:0]  psc;
    logic [15:0] low_word, high_word;
    logic        tick, scl, low_mid, high_mid, low_end, high_end;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scl_rate_gen u_scl_rate_gen (
        .clk(clk), .rst(rst), .enable(enable), .hs_mode(hs_mode), .psc(psc),
        .low_word(low_word), .high_word(high_word), .tick(tick), .scl(scl),
        .low_mid(low_mid), .high_mid(high_mid), .low_end(low_end), .high_end(high_end)
    );

    // psc, low_word, high_word, hs_mode, expected low length, expected high length (ticks)
    localparam int NV = 7;
    localparam int VEC [NV][6] = '{
        '{1, 23,      25,      0, 30,  30},
        '{1, 5,       7,       0, 12,  12},
        '{0, 'h0302,  'h0401,  0, 9,   6},
        '{0, 'h0302,  'h0401,  1, 10,  9},
        '{3, 0,       0,       0, 7,   5},
        '{1, 111,     117,     0, 118, 122},
        '{2, 'hFF10,  'h2003,  1, 262, 37}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Measures one phase at the given level, sampling 1 ns after each falling edge.
    task automatic run_phase(input logic lvl, output int cyc, output int ticks,
                             output int mids, output int mid_idx,
                             output int ends, output int end_idx);
        cyc = 0; ticks = 0; mids = 0; mid_idx = -1; ends = 0; end_idx = -1;
        while (scl == lvl && cyc < 5000) begin
            if (tick) ticks++;
            if (lvl ? high_mid : low_mid) begin mids++; mid_idx = cyc; end
            if (lvl ? high_end : low_end) begin ends++; end_idx = cyc; end
            cyc++;
            @(negedge clk); #1;
        end
    endtask

    task automatic configure(input int v);
        @(negedge clk);
        enable    = 1'b0;
        psc       = 8'(VEC[v][0]);
        low_word  = 16'(VEC[v][1]);
        high_word = 16'(VEC[v][2]);
        hs_mode   = VEC[v][3][0];
    endtask

    initial begin
        #1500000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c, t, m, mi, e, ei;
        rst = 1'b1; enable = 1'b0; hs_mode = 1'b0; psc = 8'd0;
        low_word = '0; high_word = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R6 reset scl", scl, 1);
        check("R6 reset tick", tick, 0);
        @(negedge clk); rst = 1'b0;

        // Table-driven phase measurements
        for (int v = 0; v < NV; v++) begin
            int div, ll, hl;
            div = VEC[v][0] + 1;
            ll  = VEC[v][4];
            hl  = VEC[v][5];
            configure(v);
            @(negedge clk); enable = 1'b1; #1;
            check("R5 scl low at enable", scl, 0);
            run_phase(1'b0, c, t, m, mi, e, ei);
            check(VEC[v][3] ? "R4 hs low cycles" : "R2 low cycles", c, div * ll);
            check("R1 ticks per low phase", t, ll);
            check("R7 low_mid count", m, 1);
            check("R7 low_mid position", mi, div * (ll / 2) + div - 1);
            check("R8 low_end position", ei, c - 1);
            run_phase(1'b1, c, t, m, mi, e, ei);
            check(VEC[v][3] ? "R4 hs high cycles" : "R3 high cycles", c, div * hl);
            check("R7 high_mid position", mi, div * (hl / 2) + div - 1);
            check("R8 high_end count", e, 1);
            check("R8 high_end position", ei, c - 1);
            run_phase(1'b0, c, t, m, mi, e, ei);
            check("R5 second low cycles", c, div * ll);
            @(negedge clk); enable = 1'b0; #1;
            check("R6 scl released on disable", scl, 1);
        end

        // R6: timing inputs changing while disabled have no visible effect
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                psc = 8'(k); low_word = 16'(k * 37); high_word = 16'(k * 11); hs_mode = k[0];
                #1;
                if (!scl || tick || low_mid || high_mid || low_end || high_end) seen++;
            end
            check("R6 idle activity while disabled", seen, 0);
        end

        // R6: stop part-way through a low phase, restart gives a full low phase
        configure(2);
        @(negedge clk); enable = 1'b1;
        repeat (5) @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1; #1;
        run_phase(1'b0, c, t, m, mi, e, ei);
        check("R6 restart low cycles", c, 9);

        // R1: psc = 0 ticks every cycle
        configure(3);
        @(negedge clk); enable = 1'b1; #1;
        begin
            int tc;
            tc = 0;
            for (int k = 0; k < 8; k++) begin
                if (tick) tc++;
                @(negedge clk); #1;
            end
            check("R1 psc0 tick every cycle", tc, 8);
        end
        @(negedge clk); enable = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule